// File: doc/BRIEF.md
# Dual-Group Read-Clear Interrupt Aggregator

This block collects 32 event lines from the audio routing fabric and turns each one into a sticky pending bit. Software decides, channel by channel, whether an event belongs to the urgent group or the background group. Each group drives its own interrupt request line to the processor core. A channel with its enable bit cleared is ignored.

A service routine reads the pending word of the group whose line fired. That read returns every pending channel of that group together. As a side effect, the read also clears exactly the bits it returned. No separate acknowledge write is needed, so the routine must handle every bit it sees. A small word-addressed register port holds the group-select and enable words and gives access to the two pending words. Read data appears one cycle after the read strobe.

Top module: `evt_irq_aggregator`

## Requirements
- R1: After synchronous reset, the group-select word, the enable word and all pending bits are zero, both request lines are low, and `rd_data` is zero.
- R2: A 0-to-1 transition on `evt_i[n]` sets pending bit n when enable bit n is 1. The bit stays set until a read clears it. An event input held high does not set the bit again after it has been cleared.
- R3: While enable bit n is 0, an event on channel n never sets pending bit n.
- R4: `irq_hi_o` is high while any pending bit is set whose enable bit is 1 and whose group-select bit is 1. `irq_lo_o` does the same for channels whose group-select bit is 0. The outputs follow the register state with no extra delay.
- R5: A read at offset 2 (high pending) returns pending AND enable AND group-select on `rd_data` one cycle after the strobe, and clears those bits. A read at offset 3 (low pending) does the same using the inverse of group-select. Bits of the other group are left unchanged.
- R6: When several channels of one group are pending, a single read returns all of them in one word.
- R7: If a rising event on channel n occurs in the same cycle as a read that clears bit n, bit n remains set afterwards.
- R8: A write to the group-select word moves an already pending bit to the other request line from the cycle after the write.
- R9: Offset 0 is the group-select word (bit n = 1 puts channel n in the high group). Offset 1 is the enable word. Both can be written and read back. Writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event lines, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word offset: 0 group-select, 1 enable, 2 high pending, 3 low pending |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_hi_o | output | 1 | High-group interrupt request |
| irq_lo_o | output | 1 | Low-group interrupt request |

## Verification
The bench uses several event patterns to separate the cases:
- A single pulse on one high-group channel shows that group routing is correct and that a read of the wrong group clears nothing.
- A burst across both groups, plus a later straggler, shows that one read gathers many bits and that each group clears independently.
- A level held high shows edge capture as opposed to level capture.
- An event on a disabled channel shows that the enable gate works.
- An event timed onto the clearing read shows that setting wins over clearing.
- A group-select rewrite while a bit is pending shows that the bit moves to the other request line.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_CH = 32;
    localparam int ADDR_W = 2;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PRIO = 2'd0,
        SEL_EN   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_LO   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        ch_vec_t prio;
        ch_vec_t en;
    } cfg_t;

    function automatic ch_vec_t group_mask(input ch_vec_t pend, input cfg_t cfg, input logic hi);
        return pend & cfg.en & (hi ? cfg.prio : ~cfg.prio);
    endfunction
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  ch_vec_t           wr_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(addr))
                SEL_PRIO: cfg.prio <= wr_data;
                SEL_EN:   cfg.en   <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
    import evt_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t evt_i,
    input  ch_vec_t en,
    input  ch_vec_t clr,
    output ch_vec_t pend
);
    ch_vec_t evt_q;
    ch_vec_t set_v;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_i;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign set_v[n] = evt_i[n] & ~evt_q[n] & en[n];
        always_ff @(posedge clk) begin
            if (rst)           pend[n] <= 1'b0;
            else if (set_v[n]) pend[n] <= 1'b1;
            else if (clr[n])   pend[n] <= 1'b0;
        end
    end

    assert_no_set_when_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend) & ~$past(en)) == '0));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((pend & $past(set_v)) == $past(set_v)));

    assert_sticky_until_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ((~pend & $past(pend) & ~$past(clr)) == '0));
endmodule

// File: rtl/evt_rd_port.sv
module evt_rd_port
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    input  ch_vec_t           pend,
    output ch_vec_t           clr,
    output ch_vec_t           rd_data
);
    ch_vec_t hi_vec;
    ch_vec_t lo_vec;
    ch_vec_t rd_mux;

    assign hi_vec = group_mask(pend, cfg, 1'b1);
    assign lo_vec = group_mask(pend, cfg, 1'b0);

    always_comb begin
        rd_mux = '0;
        clr    = '0;
        case (reg_sel_e'(addr))
            SEL_PRIO: rd_mux = cfg.prio;
            SEL_EN:   rd_mux = cfg.en;
            SEL_HI:   begin rd_mux = hi_vec; clr = rd_en ? hi_vec : '0; end
            SEL_LO:   begin rd_mux = lo_vec; clr = rd_en ? lo_vec : '0; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assert_hi_read_returns_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_HI) |=> (rd_data == $past(pend & cfg.en & cfg.prio)));
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] rd_data,
    output logic              irq_hi_o,
    output logic              irq_lo_o
);
    cfg_t    cfg;
    ch_vec_t pend;
    ch_vec_t clr;

    evt_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .cfg(cfg)
    );

    evt_latch_bank u_latch (
        .clk(clk), .rst(rst), .evt_i(evt_i), .en(cfg.en),
        .clr(clr), .pend(pend)
    );

    evt_rd_port u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cfg(cfg),
        .pend(pend), .clr(clr), .rd_data(rd_data)
    );

    assign irq_hi_o = |group_mask(pend, cfg, 1'b1);
    assign irq_lo_o = |group_mask(pend, cfg, 1'b0);

    assert_lines_clear_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_hi_o && !irq_lo_o && rd_data == '0));
endmodule

// File: tb/evt_irq_aggregator_tb.sv
`timescale 1ns/1ps
module evt_irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_hi_o, irq_lo_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_irq_aggregator u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic pulse(input logic [31:0] bits);
        @(negedge clk); evt_i = bits;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_hi", {31'b0, irq_hi_o}, 32'd0);
        check("R1 irq_lo", {31'b0, irq_lo_o}, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        do_read(2'd0, d); check("R1 prio", d, 32'd0);
        do_read(2'd1, d); check("R1 enable", d, 32'd0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        do_write(2'd0, 32'h0000_00F0);
        do_write(2'd1, 32'h0000_00FF);
        do_read(2'd0, d); check("R9 prio readback", d, 32'h0000_00F0);
        do_read(2'd1, d); check("R9 enable readback", d, 32'h0000_00FF);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        pulse(32'h0000_0100);
        check("R3 irq_hi", {31'b0, irq_hi_o}, 32'd0);
        check("R3 irq_lo", {31'b0, irq_lo_o}, 32'd0);
        do_read(2'd2, d); check("R3 hi pending", d, 32'd0);
        do_read(2'd3, d); check("R3 lo pending", d, 32'd0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        pulse(32'h0000_0010);
        check("R4 irq_hi set", {31'b0, irq_hi_o}, 32'd1);
        check("R4 irq_lo quiet", {31'b0, irq_lo_o}, 32'd0);
        do_read(2'd3, d); check("R5 lo read empty", d, 32'd0);
        check("R5 hi kept by lo read", {31'b0, irq_hi_o}, 32'd1);
        do_read(2'd2, d); check("R5 hi read", d, 32'h0000_0010);
        check("R5 irq_hi after clear", {31'b0, irq_hi_o}, 32'd0);
        do_read(2'd2, d); check("R5 hi reread", d, 32'd0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        pulse(32'h0000_00A3);
        pulse(32'h0000_0004);
        check("R4 irq_hi multi", {31'b0, irq_hi_o}, 32'd1);
        check("R4 irq_lo multi", {31'b0, irq_lo_o}, 32'd1);
        do_read(2'd3, d); check("R6 lo group", d, 32'h0000_0007);
        check("R6 irq_lo cleared", {31'b0, irq_lo_o}, 32'd0);
        check("R6 irq_hi kept", {31'b0, irq_hi_o}, 32'd1);
        do_read(2'd2, d); check("R6 hi group", d, 32'h0000_00A0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); evt_i = 32'h0000_0008;
        @(negedge clk);
        do_read(2'd3, d); check("R2 level first", d, 32'h0000_0008);
        do_read(2'd3, d); check("R2 level no reset", d, 32'd0);
        check("R2 irq_lo held level", {31'b0, irq_lo_o}, 32'd0);
        @(negedge clk); evt_i = '0;
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(32'h0000_0040);
        @(negedge clk); rd_en = 1'b1; addr = 2'd2; evt_i = 32'h0000_0040;
        @(negedge clk); rd_en = 1'b0; evt_i = '0;
        check("R7 colliding read data", rd_data, 32'h0000_0040);
        check("R7 irq_hi survives", {31'b0, irq_hi_o}, 32'd1);
        do_read(2'd2, d); check("R7 bit kept", d, 32'h0000_0040);
    endtask

    task automatic t_prio_move();
        logic [31:0] d;
        pulse(32'h0000_0002);
        check("R8 before move lo", {31'b0, irq_lo_o}, 32'd1);
        do_write(2'd0, 32'h0000_00F2);
        check("R8 moved hi", {31'b0, irq_hi_o}, 32'd1);
        check("R8 moved lo", {31'b0, irq_lo_o}, 32'd0);
        do_read(2'd2, d); check("R8 hi read", d, 32'h0000_0002);
    endtask

    task automatic t_wr_pending();
        logic [31:0] d;
        pulse(32'h0000_0001);
        do_write(2'd3, 32'h0000_0000);
        do_write(2'd2, 32'hFFFF_FFFF);
        do_read(2'd0, d); check("R9 prio untouched", d, 32'h0000_00F2);
        do_read(2'd1, d); check("R9 enable untouched", d, 32'h0000_00FF);
        do_read(2'd3, d); check("R9 lo pending kept", d, 32'h0000_0001);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_disabled();
        t_single();
        t_multi();
        t_level();
        t_collide();
        t_prio_move();
        t_wr_pending();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule